// File: doc/BRIEF.md
# Processor Identification Register Read Controller

This block answers read requests for the processor-identification system register. Each request carries the five encoding fields of the system-register space, the privilege level the requester runs at, and the configuration state of the machine: whether the second-highest (hypervisor) level is enabled, whether the top (monitor) level exists, the hypervisor's host-routing bit, the fine-grained trap controls, and whether ID-space trapping is implemented. One cycle after the strobe the block reports exactly one outcome: data, a trap with its target level and exception class, an undefined-instruction indication, or, when the encoding is not the identification register at all, a no-match flag.

The physical identification word is assembled from parameters: four 8-bit affinity levels, a uniprocessor flag and a multithreading flag. A 64-bit virtual copy, written only from hypervisor or monitor level, is returned instead of the physical word to level-1 readers while the hypervisor is enabled.

Top module: `pid_read_ctrl`

## Requirements
- R1: A request matches only when op0=2'b11, op1=3'b000, CRn=4'b0000, CRm=4'b0000 and op2=3'b101; any other encoding asserts only `rsp_nomatch`, with `rsp_data` zero.
- R2: Outputs register one cycle after `req_valid`; for a matching request exactly one of `rsp_valid`, `rsp_trap`, `rsp_undef` is high, and in a cycle after no request every output is zero. `rsp_data` is zero unless `rsp_valid`.
- R3: The physical word holds affinity level 3 in [39:32], a 1 in bit 31, the uniprocessor flag in bit 30, the multithreading flag in bit 24, affinity 2 in [23:16], affinity 1 in [15:8], affinity 0 in [7:0]; bits [63:40] and [29:25] are zero.
- R4: With the uniprocessor parameter set, all four affinity fields of the physical word read as zero.
- R5: A level-0 read with ID-space trapping not implemented gives `rsp_undef`.
- R6: A level-0 read with ID-space trapping implemented traps with class 0x18, to level 2 when the hypervisor is enabled and host routing is 1, otherwise to level 1.
- R7: A level-1 read traps to level 2 with class 0x18 when the hypervisor is enabled, fine-grained traps are implemented, the monitor is absent or its fine-grained enable is 1, and the read-trap bit is 1.
- R8: A level-1 read that does not trap returns the virtual copy when the hypervisor is enabled and the physical word otherwise.
- R9: Reads at levels 2 and 3 always return the physical word.
- R10: The virtual copy resets to the physical word; a write is taken only when issued at level 2 or 3, and a write at level 0 or 1 leaves the copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_lvl | input | 2 | Privilege level of the requester or writer (0..3) |
| hyp_enabled | input | 1 | Hypervisor level present and enabled |
| mon_present | input | 1 | Monitor level implemented |
| host_route | input | 1 | Hypervisor host-routing bit |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| fgt_mon_en | input | 1 | Monitor's fine-grained trap enable |
| fgt_rd_trap | input | 1 | Fine-grained read-trap bit for this register |
| idtrap_impl | input | 1 | ID-space trapping implemented |
| vcopy_we | input | 1 | Virtual copy write strobe |
| vcopy_wdata | input | 64 | Virtual copy write data |
| rsp_valid | output | 1 | Data outcome |
| rsp_data | output | 64 | Returned word |
| rsp_trap | output | 1 | Trap outcome |
| rsp_trap_lvl | output | 2 | Trap target level |
| rsp_trap_class | output | 6 | Trap exception class |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_nomatch | output | 1 | Encoding is not this register |

## Verification
The assertions assume the configuration inputs and `cur_lvl` are stable and legal during the strobe cycle and that reset is applied before the first request. The bench drives every input at the falling edge, keeps the configuration fixed while each request is in flight, and sweeps all four levels against all 128 combinations of the seven configuration bits, then perturbs each encoding field once. Virtual-copy writes are issued in cycles with no read outstanding so the expected copy stays known.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int WORD_W  = 64;
    localparam int AFF_W   = 8;
    localparam int CLASS_W = 6;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b0000;
    localparam logic [3:0] ENC_CRM = 4'b0000;
    localparam logic [2:0] ENC_OP2 = 3'b101;

    localparam logic [CLASS_W-1:0] SYSREG_TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    typedef enum logic [2:0] {
        OUT_IDLE    = 3'd0,
        OUT_DATA    = 3'd1,
        OUT_TRAP    = 3'd2,
        OUT_UNDEF   = 3'd3,
        OUT_NOMATCH = 3'd4
    } outcome_e;

    typedef struct packed {
        outcome_e   kind;
        lvl_e       target;
        logic       use_vcopy;
    } decision_t;

    typedef struct packed {
        logic hyp_enabled;
        logic mon_present;
        logic host_route;
        logic fgt_impl;
        logic fgt_mon_en;
        logic fgt_rd_trap;
        logic idtrap_impl;
    } cfg_t;

    function automatic logic [WORD_W-1:0] build_id_word(
        input logic [AFF_W-1:0] a3,
        input logic [AFF_W-1:0] a2,
        input logic [AFF_W-1:0] a1,
        input logic [AFF_W-1:0] a0,
        input logic             uni,
        input logic             mt
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[39:32] = uni ? '0 : a3;
        w[31]    = 1'b1;
        w[30]    = uni;
        w[24]    = mt;
        w[23:16] = uni ? '0 : a2;
        w[15:8]  = uni ? '0 : a1;
        w[7:0]   = uni ? '0 : a0;
        return w;
    endfunction

endpackage

// File: rtl/pid_enc_match.sv
module pid_enc_match
    import pid_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    assign hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN)
              && (crm == ENC_CRM) && (op2 == ENC_OP2);
endmodule

// File: rtl/pid_vcopy_reg.sv
module pid_vcopy_reg
    import pid_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  lvl_e              lvl,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    logic privileged;
    assign privileged = (lvl == LVL_HYP) || (lvl == LVL_MON);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (we && privileged) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/pid_access_decide.sv
module pid_access_decide
    import pid_pkg::*;
(
    input  logic      req,
    input  logic      hit,
    input  lvl_e      lvl,
    input  cfg_t      cfg,
    output decision_t dec
);
    logic fg_trap;
    assign fg_trap = cfg.hyp_enabled && cfg.fgt_impl
                  && (!cfg.mon_present || cfg.fgt_mon_en) && cfg.fgt_rd_trap;

    always_comb begin
        dec.kind      = OUT_IDLE;
        dec.target    = LVL_USER;
        dec.use_vcopy = 1'b0;
        if (!req) begin
            dec.kind = OUT_IDLE;
        end else if (!hit) begin
            dec.kind = OUT_NOMATCH;
        end else begin
            unique case (lvl)
                LVL_USER: begin
                    if (!cfg.idtrap_impl) begin
                        dec.kind = OUT_UNDEF;
                    end else begin
                        dec.kind   = OUT_TRAP;
                        dec.target = (cfg.hyp_enabled && cfg.host_route) ? LVL_HYP : LVL_KERN;
                    end
                end
                LVL_KERN: begin
                    if (fg_trap) begin
                        dec.kind   = OUT_TRAP;
                        dec.target = LVL_HYP;
                    end else begin
                        dec.kind      = OUT_DATA;
                        dec.use_vcopy = cfg.hyp_enabled;
                    end
                end
                default: begin
                    dec.kind = OUT_DATA;
                end
            endcase
        end
    end
endmodule

// File: rtl/pid_read_ctrl.sv
module pid_read_ctrl
    import pid_pkg::*;
#(
    parameter logic [7:0] AFF_L3    = 8'hA3,
    parameter logic [7:0] AFF_L2    = 8'h52,
    parameter logic [7:0] AFF_L1    = 8'h31,
    parameter logic [7:0] AFF_L0    = 8'h07,
    parameter bit         SINGLE_PE = 1'b0,
    parameter bit         MT_DEP    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [1:0]  cur_lvl,
    input  logic        hyp_enabled,
    input  logic        mon_present,
    input  logic        host_route,
    input  logic        fgt_impl,
    input  logic        fgt_mon_en,
    input  logic        fgt_rd_trap,
    input  logic        idtrap_impl,
    input  logic        vcopy_we,
    input  logic [63:0] vcopy_wdata,
    output logic        rsp_valid,
    output logic [63:0] rsp_data,
    output logic        rsp_trap,
    output logic [1:0]  rsp_trap_lvl,
    output logic [5:0]  rsp_trap_class,
    output logic        rsp_undef,
    output logic        rsp_nomatch
);
    localparam logic [WORD_W-1:0] PHYS_WORD =
        build_id_word(AFF_L3, AFF_L2, AFF_L1, AFF_L0, SINGLE_PE, MT_DEP);

    lvl_e              lvl;
    cfg_t              cfg;
    logic              hit;
    decision_t         dec;
    logic [WORD_W-1:0] vcopy_q;

    assign lvl = lvl_e'(cur_lvl);
    assign cfg = '{hyp_enabled: hyp_enabled, mon_present: mon_present,
                   host_route: host_route, fgt_impl: fgt_impl,
                   fgt_mon_en: fgt_mon_en, fgt_rd_trap: fgt_rd_trap,
                   idtrap_impl: idtrap_impl};

    pid_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (hit)
    );

    pid_vcopy_reg #(.RESET_VAL(PHYS_WORD)) u_vcopy (
        .clk   (clk),
        .rst   (rst),
        .we    (vcopy_we),
        .lvl   (lvl),
        .wdata (vcopy_wdata),
        .q     (vcopy_q)
    );

    pid_access_decide u_decide (
        .req (req_valid),
        .hit (hit),
        .lvl (lvl),
        .cfg (cfg),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_data       <= '0;
            rsp_trap       <= 1'b0;
            rsp_trap_lvl   <= '0;
            rsp_trap_class <= '0;
            rsp_undef      <= 1'b0;
            rsp_nomatch    <= 1'b0;
        end else begin
            rsp_valid      <= (dec.kind == OUT_DATA);
            rsp_data       <= (dec.kind == OUT_DATA) ? (dec.use_vcopy ? vcopy_q : PHYS_WORD) : '0;
            rsp_trap       <= (dec.kind == OUT_TRAP);
            rsp_trap_lvl   <= (dec.kind == OUT_TRAP) ? dec.target : LVL_USER;
            rsp_trap_class <= (dec.kind == OUT_TRAP) ? SYSREG_TRAP_CLASS : '0;
            rsp_undef      <= (dec.kind == OUT_UNDEF);
            rsp_nomatch    <= (dec.kind == OUT_NOMATCH);
        end
    end
endmodule

// File: rtl/pid_read_chk.sv
module pid_read_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  cur_lvl,
    input logic        rsp_valid,
    input logic [63:0] rsp_data,
    input logic        rsp_trap,
    input logic [1:0]  rsp_trap_lvl,
    input logic [5:0]  rsp_trap_class,
    input logic        rsp_undef,
    input logic        rsp_nomatch
);
    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> $countones({rsp_valid, rsp_trap, rsp_undef, rsp_nomatch}) == 1);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_valid || rsp_trap || rsp_undef || rsp_nomatch) && rsp_data == '0);

    // R1
    nomatch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_nomatch |-> rsp_data == '0);

    // R6
    trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> rsp_trap_class == 6'h18 && rsp_trap_lvl != 2'd0 && rsp_trap_lvl != 2'd3);

    // R5
    undef_user_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cur_lvl != 2'd0 |=> !rsp_undef);

    // R9
    high_lvl_data_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cur_lvl[1] |=> !rsp_trap && !rsp_undef);

    // R3
    high_lvl_layout_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cur_lvl[1] |=> !rsp_valid || (rsp_data[31] && rsp_data[63:40] == '0 && rsp_data[29:25] == '0));
endmodule

bind pid_read_ctrl pid_read_chk u_chk (.*);

// File: tb/tb_pid_read_ctrl.sv
module tb_pid_read_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [1:0]  cur_lvl;
    logic        hyp_enabled, mon_present, host_route, fgt_impl, fgt_mon_en, fgt_rd_trap, idtrap_impl;
    logic        vcopy_we;
    logic [63:0] vcopy_wdata;
    logic        rsp_valid, rsp_trap, rsp_undef, rsp_nomatch;
    logic [63:0] rsp_data;
    logic [1:0]  rsp_trap_lvl;
    logic [5:0]  rsp_trap_class;
    logic        u_valid, u_trap, u_undef, u_nomatch;
    logic [63:0] u_data;
    logic [1:0]  u_trap_lvl;
    logic [5:0]  u_trap_class;

    int checks = 0;
    int errors = 0;
    logic [63:0] phys;
    logic [63:0] exp_vcopy;

    always #2 clk = ~clk;

    pid_read_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .cur_lvl(cur_lvl), .hyp_enabled(hyp_enabled), .mon_present(mon_present), .host_route(host_route),
        .fgt_impl(fgt_impl), .fgt_mon_en(fgt_mon_en), .fgt_rd_trap(fgt_rd_trap), .idtrap_impl(idtrap_impl),
        .vcopy_we(vcopy_we), .vcopy_wdata(vcopy_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_trap(rsp_trap), .rsp_trap_lvl(rsp_trap_lvl),
        .rsp_trap_class(rsp_trap_class), .rsp_undef(rsp_undef), .rsp_nomatch(rsp_nomatch)
    );

    pid_read_ctrl #(.SINGLE_PE(1'b1)) dut_uni (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .cur_lvl(cur_lvl), .hyp_enabled(hyp_enabled), .mon_present(mon_present), .host_route(host_route),
        .fgt_impl(fgt_impl), .fgt_mon_en(fgt_mon_en), .fgt_rd_trap(fgt_rd_trap), .idtrap_impl(idtrap_impl),
        .vcopy_we(vcopy_we), .vcopy_wdata(vcopy_wdata),
        .rsp_valid(u_valid), .rsp_data(u_data), .rsp_trap(u_trap), .rsp_trap_lvl(u_trap_lvl),
        .rsp_trap_class(u_trap_class), .rsp_undef(u_undef), .rsp_nomatch(u_nomatch)
    );

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [63:0] word_of(input logic [7:0] a3, a2, a1, a0, input logic u, mt);
        return ({56'd0, a3} << 32) + (64'd1 << 31) + ({63'd0, u} << 30) + ({63'd0, mt} << 24)
             + ({56'd0, a2} << 16) + ({56'd0, a1} << 8) + {56'd0, a0};
    endfunction

    task automatic check(input string req, input logic [76:0] act, input logic [76:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_enc(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn, cm, input logic [2:0] o2);
        req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
    endtask

    task automatic set_cfg(input logic [6:0] c);
        {hyp_enabled, mon_present, host_route, fgt_impl, fgt_mon_en, fgt_rd_trap, idtrap_impl} = c;
    endtask

    // issue one request at a falling edge; outputs are sampled at the next falling edge
    task automatic read_once(input logic [1:0] lvl);
        cur_lvl = lvl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_vcopy(input logic [1:0] lvl, input logic [63:0] d);
        cur_lvl = lvl;
        vcopy_we = 1'b1;
        vcopy_wdata = d;
        @(negedge clk);
        vcopy_we = 1'b0;
        if (lvl >= 2'd2) exp_vcopy = d;
    endtask

    function automatic logic [76:0] pack_rsp();
        return {rsp_valid, rsp_trap, rsp_trap_lvl, rsp_trap_class, rsp_undef, rsp_nomatch, rsp_data};
    endfunction

    function automatic logic [76:0] expect_rsp(input logic [1:0] lvl, input logic [6:0] c);
        logic he, mp, hr, fi, fm, ft, it;
        {he, mp, hr, fi, fm, ft, it} = c;
        if (lvl == 2'd0) begin
            if (!it) return {1'b0, 1'b0, 2'd0, 6'd0, 1'b1, 1'b0, 64'd0};
            return {1'b0, 1'b1, (he && hr) ? 2'd2 : 2'd1, 6'h18, 1'b0, 1'b0, 64'd0};
        end
        if (lvl == 2'd1) begin
            if (he && fi && (!mp || fm) && ft) return {1'b0, 1'b1, 2'd2, 6'h18, 1'b0, 1'b0, 64'd0};
            return {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, he ? exp_vcopy : phys};
        end
        return {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, phys};
    endfunction

    initial begin
        phys = word_of(8'hA3, 8'h52, 8'h31, 8'h07, 1'b0, 1'b1);
        exp_vcopy = phys;
        rst = 1'b1; req_valid = 1'b0; vcopy_we = 1'b0; vcopy_wdata = '0;
        cur_lvl = 2'd0;
        set_enc(2'b11, 3'b000, 4'b0000, 4'b0000, 3'b101);
        set_cfg(7'd0);
        repeat (3) @(negedge clk);
        // R2 reset state: all outputs low
        check("R2 reset", pack_rsp(), 77'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle", pack_rsp(), 77'd0);

        // R3 layout at monitor level
        read_once(2'd3);
        check("R3 physical word", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 64'h0000_00A3_8152_3107});
        // R4 uniprocessor instance
        check("R4 uniprocessor word", {u_valid, u_data}, {1'b1, word_of(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1)});
        @(negedge clk);
        check("R2 output returns to zero", pack_rsp(), 77'd0);

        // R10 reset value of the copy seen at level 1 with hypervisor enabled
        set_cfg(7'b1000000);
        read_once(2'd1);
        check("R10 copy reset value", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, phys});
        // R10 writes at levels 0 and 1 ignored
        write_vcopy(2'd0, 64'hDEAD_0000_0000_0001);
        write_vcopy(2'd1, 64'hDEAD_0000_0000_0002);
        read_once(2'd1);
        check("R10 low-level write ignored", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, phys});
        write_vcopy(2'd2, 64'h1234_5678_9ABC_DEF0);
        read_once(2'd1);
        check("R10 level-2 write taken", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0});
        write_vcopy(2'd3, 64'h0F0F_0000_AAAA_5555);
        read_once(2'd1);
        check("R10 level-3 write taken", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 64'h0F0F_0000_AAAA_5555});

        // R5 R6 R7 R8 R9 full sweep of level and configuration
        for (int l = 0; l < 4; l++) begin
            for (int c = 0; c < 128; c++) begin
                set_cfg(7'(c));
                read_once(2'(l));
                case (l)
                    0: check("R5/R6 level-0 outcome", pack_rsp(), expect_rsp(2'(l), 7'(c)));
                    1: check("R7/R8 level-1 outcome", pack_rsp(), expect_rsp(2'(l), 7'(c)));
                    default: check("R9 high-level outcome", pack_rsp(), expect_rsp(2'(l), 7'(c)));
                endcase
            end
        end

        // R1 each encoding field perturbed in turn, at a level that would otherwise read
        set_cfg(7'd0);
        for (int f = 0; f < 5; f++) begin
            set_enc(2'b11, 3'b000, 4'b0000, 4'b0000, 3'b101);
            case (f)
                0: req_op0 = 2'b10;
                1: req_op1 = 3'b001;
                2: req_crn = 4'b1000;
                3: req_crm = 4'b0001;
                default: req_op2 = 3'b100;
            endcase
            read_once(2'd3);
            check("R1 non-matching encoding", pack_rsp(), {1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b1, 64'd0});
        end
        set_enc(2'b11, 3'b000, 4'b0000, 4'b0000, 3'b101);
        read_once(2'd2);
        check("R1 matching encoding restored", pack_rsp(), {1'b1, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, phys});

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule